// File: doc/BRIEF.md
# Mixed-Kind Pin Boundary Scan Register

This block is a boundary scan data register that sits between a core and its pad ring. Every pin is declared at elaboration with one of four kinds: input only, output only, tristate output, or bidirectional. The kind decides how many scan cells the pin receives. An input-only pin gets one cell and an output-only pin gets one. A tristate output gets two, one for data and one for enable. A bidirectional pin gets three, one for input, one for output data and one for output enable. The chain length is the sum of these counts.

A TAP controller outside the block drives single-cycle strobes for capture, shift, update and test-logic-reset, along with the serial input and the current instruction. The block chains the cells from the serial input to the serial output. It captures pad-side and core-side values and holds update latches that drive the pins in external test mode. A registered mode flag selects between functional pass-through and scan drive. Two instruction codes are recognised. Code 0 is the external test / internal test code and code 2 is the sample / preload code.

Top module: `bscan_chain`

## Requirements
- R1: Cell indices run from 0 nearest `tdo`, pin by pin in index order, and within a pin in the order input, output data, output enable. With the default pins (pin 0 input, pin 1 output, pin 2 tristate, pin 3 bidirectional) the chain has 7 cells: 0=pin0 input, 1=pin1 data, 2=pin2 data, 3=pin2 enable, 4=pin3 input, 5=pin3 data, 6=pin3 enable.
- R2: A shift strobe moves every cell one place toward `tdo`. `tdi` enters cell LEN-1, and `tdo` always shows cell 0. After LEN shifts the chain holds the shifted-in word, bit 0 first in, and returns the previous contents bit 0 first.
- R3: Update latches change only on an update strobe, when they copy the shift cells. Capture and shift strobes leave every pin output unchanged.
- R4: When the instruction is code 2, a capture strobe loads pad inputs into input cells, core data into data cells and core enables into enable cells, and the mode flag stays 0.
- R5: The mode flag is 1 in the cycle after the instruction register holds code 0. In that mode, `pad_o` and `pad_oe` come from the data and enable latches. An output-only pin has `pad_oe`=1 and an input-only pin has `pad_oe`=0.
- R6: In external mode, `core_i` of input and bidirectional pins shows the input latch and ignores changes on `pad_i`.
- R7: With the mode flag 0, `pad_o`=`core_o` and `pad_oe`=`core_oe` for tristate and bidirectional pins. An output-only pin has `pad_oe`=1 and `pad_o`=`core_o`. `core_i`=`pad_i` for input and bidirectional pins. Pins with no input path present `core_i`=0, and input-only pins present `pad_o`=0.
- R8: Under any instruction other than codes 0 and 2, capture, shift and update strobes leave the shift cells and latches unchanged, and the mode flag is 0.
- R9: A test-logic-reset strobe clears every shift cell, every update latch and the mode flag on that edge, which returns all pins to pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | test clock |
| rst_n | input | 1 | asynchronous reset, active low |
| tlr | input | 1 | test-logic-reset strobe |
| capture_dr | input | 1 | capture strobe |
| shift_dr | input | 1 | shift strobe |
| update_dr | input | 1 | update strobe |
| tdi | input | 1 | serial scan input |
| ir | input | IR_W | current instruction code |
| tdo | output | 1 | serial scan output (cell 0) |
| ext_mode | output | 1 | 1 = pins driven from scan latches |
| core_o | input | NPINS | core output data per pin |
| core_oe | input | NPINS | core output enable per pin |
| core_i | output | NPINS | input value presented to the core |
| pad_i | input | NPINS | value received from the pad |
| pad_o | output | NPINS | data driven to the pad |
| pad_oe | output | NPINS | pad output enable |

## Verification
The properties assume the TAP controller asserts at most one of capture, shift, update and test-logic-reset in any cycle. They also assume `ir` changes only between strobes. Every bench task raises one strobe for one clock and changes `ir` or pin inputs on the falling edge when no strobe is active, so both assumptions hold throughout. Expected capture words and pin values are derived in the bench from the cell layout stated in R1.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

   localparam int MAX_PINS = 64;
   localparam int KV_W     = 2 * MAX_PINS;

   typedef enum logic [1:0] {
      KIND_IN   = 2'd0,
      KIND_OUT  = 2'd1,
      KIND_TRI  = 2'd2,
      KIND_BIDI = 2'd3
   } pin_kind_e;

   function automatic int cell_count(input logic [1:0] kind);
      case (kind)
         2'd2:    return 2;
         2'd3:    return 3;
         default: return 1;
      endcase
   endfunction

   // first cell index of pin p (sum of the counts of all lower pins)
   function automatic int cell_base(input logic [KV_W-1:0] kinds, input int p);
      int acc;
      acc = 0;
      for (int i = 0; i < p; i++) acc += cell_count(kinds[2*i +: 2]);
      return acc;
   endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic cap_en,
   input  logic shift_en,
   input  logic upd_en,
   input  logic cap_d,
   input  logic ser_in,
   output logic sh_q,
   output logic upd_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= 1'b0;
         upd_q <= 1'b0;
      end else if (clr) begin
         sh_q  <= 1'b0;
         upd_q <= 1'b0;
      end else begin
         if (cap_en)        sh_q <= cap_d;
         else if (shift_en) sh_q <= ser_in;
         if (upd_en)        upd_q <= sh_q;
      end
   end

endmodule

// File: rtl/bscan_pin.sv
module bscan_pin #(
   parameter bscan_pkg::pin_kind_e KIND = bscan_pkg::KIND_IN,
   parameter int NC = 1
) (
   input  logic          mode,
   input  logic          core_o,
   input  logic          core_oe,
   input  logic          pad_i,
   input  logic [NC-1:0] upd,
   output logic [NC-1:0] cap,
   output logic          core_i,
   output logic          pad_o,
   output logic          pad_oe
);

   if (NC != bscan_pkg::cell_count(KIND)) begin : g_bad_nc
      $error("bscan_pin: NC does not match pin kind");
   end

   if (KIND == bscan_pkg::KIND_IN) begin : g_in
      logic unused_core;
      assign unused_core = core_o ^ core_oe;
      assign cap[0] = pad_i;
      assign core_i = mode ? upd[0] : pad_i;
      assign pad_o  = 1'b0;
      assign pad_oe = 1'b0;
   end else if (KIND == bscan_pkg::KIND_OUT) begin : g_out
      logic unused_in;
      assign unused_in = core_oe ^ pad_i;
      assign cap[0] = core_o;
      assign core_i = 1'b0;
      assign pad_o  = mode ? upd[0] : core_o;
      assign pad_oe = 1'b1;
   end else if (KIND == bscan_pkg::KIND_TRI) begin : g_tri
      logic unused_in;
      assign unused_in = pad_i;
      assign cap    = {core_oe, core_o};
      assign core_i = 1'b0;
      assign pad_o  = mode ? upd[0] : core_o;
      assign pad_oe = mode ? upd[1] : core_oe;
   end else begin : g_bidi
      assign cap    = {core_oe, core_o, pad_i};
      assign core_i = mode ? upd[0] : pad_i;
      assign pad_o  = mode ? upd[1] : core_o;
      assign pad_oe = mode ? upd[2] : core_oe;
   end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
   parameter int                  NPINS     = 4,
   parameter logic [2*NPINS-1:0]  PIN_KINDS = {2'd3, 2'd2, 2'd1, 2'd0},
   parameter int                  IR_W      = 4,
   parameter logic [IR_W-1:0]     IR_EXT    = '0,
   parameter logic [IR_W-1:0]     IR_SAMPLE = IR_W'(2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tlr,
   input  logic             capture_dr,
   input  logic             shift_dr,
   input  logic             update_dr,
   input  logic             tdi,
   input  logic [IR_W-1:0]  ir,
   output logic             tdo,
   output logic             ext_mode,
   input  logic [NPINS-1:0] core_o,
   input  logic [NPINS-1:0] core_oe,
   output logic [NPINS-1:0] core_i,
   input  logic [NPINS-1:0] pad_i,
   output logic [NPINS-1:0] pad_o,
   output logic [NPINS-1:0] pad_oe
);
   import bscan_pkg::*;

   localparam logic [KV_W-1:0] KINDS = KV_W'(PIN_KINDS);
   localparam int LEN = cell_base(KINDS, NPINS);

   if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_npins
      $error("bscan_chain: NPINS out of range");
   end
   if (IR_EXT == IR_SAMPLE) begin : g_bad_codes
      $error("bscan_chain: instruction codes must differ");
   end

   logic           chain_sel;
   logic           cap_en, shift_en, upd_en;
   logic [LEN-1:0] cap_v, sh_v, upd_v;

   assign chain_sel = (ir == IR_EXT) || (ir == IR_SAMPLE);
   assign cap_en    = capture_dr & chain_sel;
   assign shift_en  = shift_dr   & chain_sel;
   assign upd_en    = update_dr  & chain_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ext_mode <= 1'b0;
      else if (tlr) ext_mode <= 1'b0;
      else          ext_mode <= (ir == IR_EXT);
   end

   for (genvar c = 0; c < LEN; c++) begin : g_cell
      logic ser;
      if (c == LEN - 1) begin : g_head
         assign ser = tdi;
      end else begin : g_link
         assign ser = sh_v[c+1];
      end
      bscan_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (tlr),
         .cap_en   (cap_en),
         .shift_en (shift_en),
         .upd_en   (upd_en),
         .cap_d    (cap_v[c]),
         .ser_in   (ser),
         .sh_q     (sh_v[c]),
         .upd_q    (upd_v[c])
      );
   end

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      localparam pin_kind_e K  = pin_kind_e'(KINDS[2*p +: 2]);
      localparam int        NC = cell_count(K);
      localparam int        B  = cell_base(KINDS, p);
      bscan_pin #(.KIND(K), .NC(NC)) u_pin (
         .mode    (ext_mode),
         .core_o  (core_o[p]),
         .core_oe (core_oe[p]),
         .pad_i   (pad_i[p]),
         .upd     (upd_v[B +: NC]),
         .cap     (cap_v[B +: NC]),
         .core_i  (core_i[p]),
         .pad_o   (pad_o[p]),
         .pad_oe  (pad_oe[p])
      );
   end

   assign tdo = sh_v[0];

endmodule

module bscan_chain_chk #(
   parameter int              LEN    = 7,
   parameter int              IR_W   = 4,
   parameter logic [IR_W-1:0] IR_EXT = '0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tlr,
   input logic            capture_dr,
   input logic            shift_dr,
   input logic            update_dr,
   input logic            chain_sel,
   input logic [IR_W-1:0] ir,
   input logic            tdo,
   input logic            ext_mode,
   input logic [LEN-1:0]  cap_v,
   input logic [LEN-1:0]  sh_v,
   input logic [LEN-1:0]  upd_v
);

   p_capture_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (capture_dr && chain_sel && !tlr) |=> (tdo == $past(cap_v[0])));

   if (LEN > 1) begin : g_shift_chk
      p_shift_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (shift_dr && !capture_dr && chain_sel && !tlr) |=> (tdo == $past(sh_v[1])));
   end

   p_latch_only_on_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!update_dr && !tlr) |=> $stable(upd_v));

   p_mode_tracks_ir_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tlr |=> (ext_mode == ($past(ir) == IR_EXT)));

   p_unselected_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!chain_sel && !tlr) |=> ($stable(sh_v) && $stable(upd_v)));

   p_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tlr |=> (!ext_mode && sh_v == '0 && upd_v == '0));

endmodule

bind bscan_chain bscan_chain_chk #(.LEN(LEN), .IR_W(IR_W), .IR_EXT(IR_EXT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tlr        (tlr),
   .capture_dr (capture_dr),
   .shift_dr   (shift_dr),
   .update_dr  (update_dr),
   .chain_sel  (chain_sel),
   .ir         (ir),
   .tdo        (tdo),
   .ext_mode   (ext_mode),
   .cap_v      (cap_v),
   .sh_v       (sh_v),
   .upd_v      (upd_v)
);

// File: tb/bscan_chain_test.sv
module bscan_chain_test;

   localparam int CLK_PERIOD = 10;
   localparam int LEN = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tlr = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
   logic       tdi = 1'b0;
   logic [3:0] ir = 4'd4;
   logic       tdo, ext_mode;
   logic [3:0] core_o = '0, core_oe = '0, pad_i = '0;
   logic [3:0] core_i, pad_o, pad_oe;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bscan_chain uut (
      .clk(clk), .rst_n(rst_n), .tlr(tlr), .capture_dr(capture_dr),
      .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .ir(ir),
      .tdo(tdo), .ext_mode(ext_mode), .core_o(core_o), .core_oe(core_oe),
      .core_i(core_i), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // expected capture word from the R1 layout
   function automatic logic [LEN-1:0] exp_cap();
      return {core_oe[3], core_o[3], pad_i[3], core_oe[2], core_o[2], core_o[1], pad_i[0]};
   endfunction

   task automatic check_pads(input string req, input bit ext, input logic [LEN-1:0] l);
      if (ext) begin
         chk({req, " pad_o"},  pad_o,  {l[5], l[2], l[1], 1'b0});
         chk({req, " pad_oe"}, pad_oe, {l[6], l[3], 1'b1, 1'b0});
         chk({req, " core_i"}, core_i, {l[4], 1'b0, 1'b0, l[0]});
      end else begin
         chk({req, " pad_o"},  pad_o,  {core_o[3:1], 1'b0});
         chk({req, " pad_oe"}, pad_oe, {core_oe[3:2], 1'b1, 1'b0});
         chk({req, " core_i"}, core_i, {pad_i[3], 2'b00, pad_i[0]});
      end
   endtask

   task automatic set_ir(input logic [3:0] code);
      ir = code;
      @(negedge clk);
   endtask

   task automatic do_capture;
      capture_dr = 1'b1;
      @(negedge clk);
      capture_dr = 1'b0;
   endtask

   task automatic do_update;
      update_dr = 1'b1;
      @(negedge clk);
      update_dr = 1'b0;
   endtask

   task automatic shift_word(input logic [LEN-1:0] din, output logic [LEN-1:0] dout);
      for (int i = 0; i < LEN; i++) begin
         dout[i] = tdo;
         tdi = din[i];
         shift_dr = 1'b1;
         @(negedge clk);
      end
      shift_dr = 1'b0;
      tdi = 1'b0;
   endtask

   task automatic t_reset;
      chk("R9 reset tdo", tdo, 0);
      chk("R9 reset mode", ext_mode, 0);
      core_o = 4'b1010; core_oe = 4'b0110; pad_i = 4'b1001;
      @(negedge clk);
      check_pads("R7 passthru", 0, '0);
   endtask

   task automatic t_sample;
      logic [LEN-1:0] got;
      set_ir(4'd2);
      pad_i = 4'b0001; core_o = 4'b0100; core_oe = 4'b1100;
      @(negedge clk);
      do_capture;
      shift_word(7'b0110010, got);
      chk("R4 R1 sample capture", got, exp_cap());
      chk("R4 mode stays 0", ext_mode, 0);
      check_pads("R4 functional kept", 0, '0);
      shift_word('0, got);
      chk("R2 chain length", got, 7'b0110010);
      shift_word(7'b0110010, got);
      chk("R2 zeros return", got, 0);
      check_pads("R3 no change on shift", 0, '0);
      do_update;
      check_pads("R4 functional after update", 0, '0);
   endtask

   task automatic t_extest;
      logic [LEN-1:0] got, cap;
      set_ir(4'd0);
      chk("R5 mode set", ext_mode, 1);
      check_pads("R5 preload drive", 1, 7'b0110010);
      pad_i = 4'b1000; core_o = 4'b1011; core_oe = 4'b0011;
      @(negedge clk);
      check_pads("R6 core_i held", 1, 7'b0110010);
      cap = exp_cap();
      do_capture;
      shift_word(7'b1010101, got);
      chk("R5 extest capture", got, cap);
      check_pads("R3 drive kept during shift", 1, 7'b0110010);
      do_update;
      check_pads("R5 new drive", 1, 7'b1010101);
   endtask

   task automatic t_other;
      logic [LEN-1:0] got;
      set_ir(4'd2);
      shift_word(7'b0011100, got);
      chk("R2 returns prior", got, 7'b1010101);
      set_ir(4'd5);
      chk("R8 mode 0", ext_mode, 0);
      check_pads("R8 passthru", 0, '0);
      do_capture;
      shift_word(7'b1111111, got);
      do_update;
      chk("R8 tdo held", got, 7'b0000000);
      set_ir(4'd0);
      check_pads("R8 update ignored", 1, 7'b1010101);
      set_ir(4'd2);
      shift_word('0, got);
      chk("R8 shift ignored", got, 7'b0011100);
   endtask

   task automatic t_tlr;
      logic [LEN-1:0] got;
      shift_word(7'b1100110, got);
      set_ir(4'd0);
      chk("R9 pre mode", ext_mode, 1);
      tlr = 1'b1;
      @(negedge clk);
      tlr = 1'b0;
      chk("R9 mode cleared", ext_mode, 0);
      check_pads("R9 passthru", 0, '0);
      @(negedge clk);
      chk("R9 mode back", ext_mode, 1);
      check_pads("R9 latches cleared", 1, '0);
      shift_word('0, got);
      chk("R9 shift cells cleared", got, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_sample;
      t_extest;
      t_other;
      t_tlr;
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule